// File: doc/BRIEF.md
# Framed Time-Slot Gate

This block marks, one bit period at a time, where a receive channel and a transmit channel sit inside a frame on a time-slot oriented PCM link. Both directions run from one common, externally supplied bit clock. That clock reaches the block as a one-cycle bit enable in the system clock domain. A frame synchronization input sets the bit position counter back to zero. The block counts bit positions from there. Each direction's enable is high only while the count lies inside that direction's programmed window.

Each direction has its own window placement and its own window length. The placement is a 6-bit slot number, which counts in units of eight bits, plus a 3-bit fine offset of 0 to 7 bits. Together they give a 9-bit starting position from 0 to 511. The length is an 8-bit field that holds the number of bits minus one, so a window spans 1 to 256 bits. The block latches its settings only when it samples a frame sync. A window that is already running therefore cannot be disturbed by a change to the settings. Data shifting and line coding belong to other blocks, and the data is assumed to be NRZ.

Top module: `tslot_gate`

## Requirements
- R1: After reset, and until the first bit enable that samples frame sync high, both window outputs stay low.
- R2: A bit enable with `fsync` high makes that bit position 0 of the new frame. The outputs for position 0 appear in the cycle after that bit enable.
- R3: Every later bit enable with `fsync` low advances the position by one. In cycles without a bit enable, the position and both outputs hold their values.
- R4: The position stops at 511 and stays there until the next frame sync.
- R5: `rx_win` is high exactly when the position lies within S to S+L. Here S = `rx_slot`*8 + `rx_shift` and L = `rx_len`, so `rx_len`=0 gives one bit and 255 gives 256 bits.
- R6: `tx_win` follows the same rule with `tx_slot`, `tx_shift` and `tx_len`. It is independent of the receive settings.
- R7: A window whose end lies past position 511 stays high at the stopped position 511 and is cut off only when the next frame sync arrives.
- R8: Settings that change between frame syncs have no effect until the next frame sync is sampled, so a window in progress keeps its start and length.
- R9: A frame sync that arrives in mid-window restarts the count at once. It uses the settings present on the inputs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per period of the common bit clock |
| fsync | input | 1 | Frame sync, sampled when bit_en is high |
| rx_slot | input | 6 | Receive slot number (units of 8 bits) |
| rx_shift | input | 3 | Receive fine offset in bits |
| rx_len | input | 8 | Receive window length minus one |
| tx_slot | input | 6 | Transmit slot number (units of 8 bits) |
| tx_shift | input | 3 | Transmit fine offset in bits |
| tx_len | input | 8 | Transmit window length minus one |
| rx_win | output | 1 | Receive window enable for the current bit |
| tx_win | output | 1 | Transmit window enable for the current bit |

## Verification
Two functions can fall in the same bit: a frame sync that restarts the count, and a change of settings that the sync must capture. A third case also coincides with a sync: a window that is still running, possibly held open at position 511. The bench provokes the first case by changing the settings in the same cycle as the sync pulse, while a window is open. It then judges, bit by bit, that position 0 onward follows the new settings and never the old ones. It also checks that a settings change with no sync leaves the running window exactly as it was.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int unsigned TSG_SLOT_W  = 6;
  localparam int unsigned TSG_SHIFT_W = 3;
  localparam int unsigned TSG_LEN_W   = 8;
  localparam int unsigned TSG_NDIR    = 2;

  typedef enum logic [0:0] {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } tsg_dir_e;
endpackage

// File: rtl/tsg_pos_counter.sv
module tsg_pos_counter #(
  parameter int unsigned POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  output logic [POS_W-1:0] pos,
  output logic             framed,
  output logic             sync_tick
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_nxt;
  logic             framed_nxt;

  assign sync_tick = bit_en & fsync;

  always_comb begin
    pos_nxt    = pos;
    framed_nxt = framed;
    if (sync_tick) begin
      pos_nxt    = '0;
      framed_nxt = 1'b1;
    end else if (pos != POS_MAX) begin
      pos_nxt = pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      framed <= 1'b0;
    end else if (bit_en) begin
      pos    <= pos_nxt;
      framed <= framed_nxt;
    end
  end

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (pos == '0 && framed)); // R2
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(pos) && $stable(framed))); // R3
  AST_POS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !fsync && pos == POS_MAX) |=> (pos == POS_MAX)); // R4
endmodule

// File: rtl/tsg_window.sv
module tsg_window #(
  parameter int unsigned SLOT_W  = 6,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned POS_W   = SLOT_W + SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               framed,
  input  logic [POS_W-1:0]   pos,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [LEN_W-1:0]   cfg_len,
  output logic               win
);
  localparam int unsigned LAST_W = ((POS_W > LEN_W) ? POS_W : LEN_W) + 1;

  logic [POS_W-1:0]  start_q, start_d;
  logic [LAST_W-1:0] last_q, last_d;

  always_comb begin
    start_d = start_q;
    last_d  = last_q;
    if (load) begin
      start_d = {cfg_slot, cfg_shift};
      last_d  = LAST_W'({cfg_slot, cfg_shift}) + LAST_W'(cfg_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      start_q <= start_d;
      last_q  <= last_d;
    end
  end

  always_comb begin
    win = framed && (pos >= start_q) && (LAST_W'(pos) <= last_q);
  end

  AST_WIN_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |-> !win); // R1
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(start_q) && $stable(last_q))); // R8
  AST_WIN_MOVES_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == $past(pos) && !$past(load)) |-> $stable(win)); // R3
endmodule

// File: rtl/tslot_gate.sv
module tslot_gate
  import tsg_pkg::*;
#(
  parameter int unsigned SLOT_W  = TSG_SLOT_W,
  parameter int unsigned SHIFT_W = TSG_SHIFT_W,
  parameter int unsigned LEN_W   = TSG_LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               fsync,
  input  logic [SLOT_W-1:0]  rx_slot,
  input  logic [SHIFT_W-1:0] rx_shift,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic [SLOT_W-1:0]  tx_slot,
  input  logic [SHIFT_W-1:0] tx_shift,
  input  logic [LEN_W-1:0]   tx_len,
  output logic               rx_win,
  output logic               tx_win
);
  localparam int unsigned POS_W = SLOT_W + SHIFT_W;

  logic [POS_W-1:0]   pos;
  logic               framed;
  logic               sync_tick;
  logic [SLOT_W-1:0]  slot_a  [TSG_NDIR];
  logic [SHIFT_W-1:0] shift_a [TSG_NDIR];
  logic [LEN_W-1:0]   len_a   [TSG_NDIR];
  logic [TSG_NDIR-1:0] win_a;

  assign slot_a[DIR_RX]  = rx_slot;
  assign shift_a[DIR_RX] = rx_shift;
  assign len_a[DIR_RX]   = rx_len;
  assign slot_a[DIR_TX]  = tx_slot;
  assign shift_a[DIR_TX] = tx_shift;
  assign len_a[DIR_TX]   = tx_len;

  tsg_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .fsync     (fsync),
    .pos       (pos),
    .framed    (framed),
    .sync_tick (sync_tick)
  );

  for (genvar d = 0; d < TSG_NDIR; d++) begin : g_dir
    tsg_window #(
      .SLOT_W  (SLOT_W),
      .SHIFT_W (SHIFT_W),
      .LEN_W   (LEN_W),
      .POS_W   (POS_W)
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sync_tick),
      .framed    (framed),
      .pos       (pos),
      .cfg_slot  (slot_a[d]),
      .cfg_shift (shift_a[d]),
      .cfg_len   (len_a[d]),
      .win       (win_a[d])
    );
  end

  assign rx_win = win_a[DIR_RX];
  assign tx_win = win_a[DIR_TX];

  AST_RESTART_AT_ZERO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_tick && rx_slot == '0 && rx_shift == '0) |=> rx_win); // R9
  AST_RESTART_AT_ZERO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_tick && tx_slot == '0 && tx_shift == '0) |=> tx_win); // R9
endmodule

// File: tb/sim_tslot_gate.sv
module sim_tslot_gate;
  logic clk = 1'b0;
  logic rst_n, bit_en, fsync;
  logic [5:0] rx_slot, tx_slot;
  logic [2:0] rx_shift, tx_shift;
  logic [7:0] rx_len, tx_len;
  logic rx_win, tx_win;

  int checks = 0;
  int errors = 0;
  int mpos = 0;
  bit mframed = 1'b0;
  int rx_s = 0, rx_l = 0, tx_s = 0, tx_l = 0;

  always #4 clk = ~clk;

  tslot_gate u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .rx_slot(rx_slot), .rx_shift(rx_shift), .rx_len(rx_len),
    .tx_slot(tx_slot), .tx_shift(tx_shift), .tx_len(tx_len),
    .rx_win(rx_win), .tx_win(tx_win)
  );

  // Each entry: rx_slot, rx_shift, rx_len, tx_slot, tx_shift, tx_len
  localparam int NVEC = 6;
  localparam logic [33:0] VEC [NVEC] = '{
    {6'd0,  3'd0, 8'd0,   6'd0,  3'd0, 8'd255},
    {6'd3,  3'd5, 8'd9,   6'd1,  3'd2, 8'd3},
    {6'd63, 3'd7, 8'd255, 6'd63, 3'd0, 8'd7},
    {6'd31, 3'd1, 8'd127, 6'd10, 3'd7, 8'd0},
    {6'd60, 3'd0, 8'd100, 6'd2,  3'd4, 8'd200},
    {6'd0,  3'd7, 8'd255, 6'd50, 3'd3, 8'd254}
  };

  function automatic bit exp_win(int s, int l);
    return mframed && (mpos >= s) && (mpos <= s + l);
  endfunction

  task automatic check_outs(string tag);
    bit er, et;
    er = exp_win(rx_s, rx_l);
    et = exp_win(tx_s, tx_l);
    checks++;
    if (rx_win !== er || tx_win !== et) begin
      errors++;
      $display("FAIL %s pos=%0d rx_win=%b exp %b tx_win=%b exp %b",
               tag, mpos, rx_win, er, tx_win, et);
    end
  endtask

  task automatic step(input bit fs, input string tag);
    @(negedge clk);
    bit_en = 1'b1;
    fsync  = fs;
    @(posedge clk);
    if (fs) begin
      mpos = 0; mframed = 1'b1;
      rx_s = int'(rx_slot) * 8 + int'(rx_shift); rx_l = int'(rx_len);
      tx_s = int'(tx_slot) * 8 + int'(tx_shift); tx_l = int'(tx_len);
    end else if (mpos < 511) begin
      mpos++;
    end
    @(negedge clk);
    bit_en = 1'b0;
    fsync  = 1'b0;
    check_outs(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_outs(tag);
    end
  endtask

  task automatic set_cfg(logic [33:0] v);
    {rx_slot, rx_shift, rx_len, tx_slot, tx_shift, tx_len} = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0;
    set_cfg({6'd0, 3'd0, 8'd3, 6'd0, 3'd0, 8'd3});
    repeat (3) @(negedge clk);
    check_outs("R1 reset");
    rst_n = 1'b1;
    // R1: bits counted before any sync must not open a window
    for (int i = 0; i < 6; i++) step(1'b0, "R1 no frame yet");

    // Table walk: R2 R3 R4 R5 R6 R7 over full frames
    for (int i = 0; i < NVEC; i++) begin
      set_cfg(VEC[i]);
      step(1'b1, "R2 sync");
      for (int j = 0; j < 530; j++) step(1'b0, "R5/R6 window");
    end

    // R3: gaps between bit enables hold the window edge
    set_cfg({6'd0, 3'd2, 8'd0, 6'd0, 3'd3, 8'd1});
    step(1'b1, "R3 sync");
    step(1'b0, "R3 pos1");
    idle(5, "R3 hold");
    step(1'b0, "R3 pos2 rx opens");
    idle(4, "R3 hold open");
    step(1'b0, "R3 pos3");
    step(1'b0, "R3 pos4");
    step(1'b0, "R3 pos5");

    // R4/R7: window at 511 stays open past saturation, closes on sync
    set_cfg({6'd63, 3'd7, 8'd0, 6'd63, 3'd6, 8'd40});
    step(1'b1, "R7 sync");
    for (int j = 0; j < 520; j++) step(1'b0, "R4 R7 saturate");
    set_cfg({6'd1, 3'd0, 8'd0, 6'd1, 3'd0, 8'd0});
    step(1'b1, "R7 cut by sync");
    step(1'b0, "R7 after sync");

    // R8: settings changed mid-window without sync are ignored
    set_cfg({6'd0, 3'd4, 8'd3, 6'd0, 3'd5, 8'd2});
    step(1'b1, "R8 sync");
    for (int j = 0; j < 5; j++) step(1'b0, "R8 before change");
    set_cfg({6'd12, 3'd0, 8'd0, 6'd0, 3'd0, 8'd0});
    for (int j = 0; j < 10; j++) step(1'b0, "R8 old window kept");
    step(1'b1, "R8 new sync");
    for (int j = 0; j < 100; j++) step(1'b0, "R8 new window");

    // R9: sync and new settings in the same bit, mid-window
    set_cfg({6'd0, 3'd0, 8'd20, 6'd0, 3'd1, 8'd20});
    step(1'b1, "R9 sync");
    for (int j = 0; j < 10; j++) step(1'b0, "R9 open");
    set_cfg({6'd0, 3'd0, 8'd1, 6'd0, 3'd3, 8'd0});
    step(1'b1, "R9 resync");
    for (int j = 0; j < 6; j++) step(1'b0, "R9 short window");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule